// File: doc/BRIEF.md
# Word-Access Block Cipher Bus Port

This block is the register front end of a 128-bit block cipher engine. Software or a DMA controller programs a 128-bit key and a 128-bit initialization vector as four 32-bit words each. Plaintext is pushed one 32-bit word at a time through a single input data register, and the processed block is pulled back one 32-bit word at a time through a single output data register. The first word written or read is always the most significant word of the block. When the fourth input word arrives, the engine starts by itself. The four result words become readable once the engine reports done.

The slave accepts only aligned single full-word accesses. Any other size or alignment gets a two-cycle error response, and a write of that kind changes nothing. A swap setting converts between the memory layout of 8-, 16- or 1-bit data and the engine's word layout. The conversion is applied to each input word, and the same involution undoes it on each output word. Two request lines pace a single-word DMA controller: one for loading and one for unloading. A sticky status bit marks each finished block until software clears it. The cipher here is a stub with a fixed latency whose result is the data XOR key XOR initialization vector.

Word map, by address bits [5:2]: 0 control, 1 status, 2 data in, 3 data out, 4..7 key words, 8..11 initialization-vector words. In both the key and the vector, the lowest address holds the most significant word.

Top module: `blkc_bus_port`

## Requirements
- R1: An access whose size code is not 2 (32-bit), or whose address bits [1:0] are not 0, gets bus_err=1 with bus_ready=0 in the first cycle after the request, then bus_err=1 with bus_ready=1 in the second cycle. A good access gets bus_ready=1 and bus_err=0 in the first cycle after the request.
- R2: A rejected write leaves every register unchanged (control, key and initialization vector), and the register reads back its earlier value.
- R3: The key words (offsets 4..7) and the initialization-vector words (offsets 8..11) are each writable and read back as written. Control, status and all key and vector words read 0 after reset.
- R4: The four data-in writes fill the block most significant word first. After the fourth write the engine starts without any further command. The four data-out reads return the result most significant word first, each read advancing to the next word.
- R5: The swap field, control bits [2:1], selects the conversion: 0 none, 1 swap the 16-bit halves, 2 reverse the byte order, 3 reverse the bit order. Each input word is converted before it enters the block, and each result word is converted before it is read. The stub result word i is conv(conv(in_i) XOR key_i XOR iv_i).
- R6: dma_in_req equals enable (control bit 0) AND the input-DMA enable (control bit 3) while the block is loading. It is low from the fourth data-in write until the fourth data-out read.
- R7: dma_out_req, when the output-DMA enable (control bit 4) is set, rises exactly ENG_LAT+2 cycles after the fourth data-in write. It stays high until the fourth data-out read.
- R8: Status bit 0 becomes 1 when the engine finishes and stays 1 until a control write with bit 7 set. Control bit 7 always reads 0.
- R9: Clearing the enable bit discards a partially loaded block and resets both word counters. Data-in writes made while the block is disabled are ignored.
- R10: A data-out read while no result is pending returns 0 and does not disturb the next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | One-cycle access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Access size code: 0 byte, 1 half-word, 2 word |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ready |
| bus_ready | output | 1 | Access completion |
| bus_err | output | 1 | Error response |
| dma_in_req | output | 1 | Request for the next input word |
| dma_out_req | output | 1 | Request to read the next output word |

## Verification
Every bus response, register update and counter step is registered on the edge that samples the request. The bench therefore reads bus_ready, bus_err and bus_rdata at the falling edge that follows that sampling edge, and for an error it checks the second phase one falling edge later. The engine start is one register stage behind the fourth data-in write, the stub takes ENG_LAT cycles, and the sequencer adds one more stage. For that reason the bench counts falling edges from the fourth write: it requires dma_out_req low after ENG_LAT+1 edges and high after ENG_LAT+2, and it requires the status bit set at that same point. dma_in_req is sampled at the falling edge right after the fourth write and again after the fourth read. This is repeated for all four swap settings, with expected words built from an independently written bit-index swap.

// File: rtl/bbp_pkg.sv
package bbp_pkg;
  localparam int WORD_W    = 32;
  localparam int BLK_WORDS = 4;
  localparam int BLK_W     = WORD_W * BLK_WORDS;
  localparam int CNT_W     = $clog2(BLK_WORDS);
  localparam int ADDR_W    = 6;
  localparam int IDX_W     = ADDR_W - 2;

  localparam logic [IDX_W-1:0] OFS_CTRL = 4'd0;
  localparam logic [IDX_W-1:0] OFS_STAT = 4'd1;
  localparam logic [IDX_W-1:0] OFS_DIN  = 4'd2;
  localparam logic [IDX_W-1:0] OFS_DOUT = 4'd3;
  localparam logic [IDX_W-1:0] OFS_KEY  = 4'd4;
  localparam logic [IDX_W-1:0] OFS_IV   = 4'd8;

  typedef enum logic [1:0] {PH_LOAD = 2'd0, PH_BUSY = 2'd1, PH_UNLOAD = 2'd2} phase_t;
  typedef enum logic [1:0] {SW_NONE = 2'd0, SW_HALF = 2'd1, SW_BYTE = 2'd2, SW_BIT = 2'd3} swap_t;

  // Each conversion is its own inverse, so the same function serves both directions.
  function automatic logic [WORD_W-1:0] swap_word(swap_t m, logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] r;
    r = w;
    case (m)
      SW_HALF: r = {w[15:0], w[31:16]};
      SW_BYTE: r = {w[7:0], w[15:8], w[23:16], w[31:24]};
      SW_BIT:  for (int i = 0; i < WORD_W; i++) r[i] = w[WORD_W-1-i];
      default: r = w;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/bbp_regs.sv
module bbp_regs
  import bbp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [1:0]        bus_size,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              bus_ready,
  output logic              bus_err,
  output logic              en,
  output swap_t             swap_mode,
  output logic              din_dma_en,
  output logic              dout_dma_en,
  output logic [BLK_W-1:0]  key_flat,
  output logic [BLK_W-1:0]  iv_flat,
  output logic              wr_din,
  output logic              rd_dout,
  output logic              clr_cmp,
  input  logic [WORD_W-1:0] dout_word,
  input  logic              cmp_flag
);
  logic [WORD_W-1:0] key_w [BLK_WORDS];
  logic [WORD_W-1:0] iv_w  [BLK_WORDS];
  logic              ok_q, err_ph1, err_ph2;
  logic [WORD_W-1:0] rdata_q, rd_val;
  logic [IDX_W-1:0]  widx;
  logic              acc, size_ok, good, bad, wr_good, rd_good;

  assign widx    = bus_addr[ADDR_W-1:2];
  assign acc     = bus_valid && !err_ph1;
  assign size_ok = (bus_size == 2'b10) && (bus_addr[1:0] == 2'b00);
  assign good    = acc && size_ok;
  assign bad     = acc && !size_ok;
  assign wr_good = good && bus_write;
  assign rd_good = good && !bus_write;
  assign wr_din  = wr_good && (widx == OFS_DIN);
  assign rd_dout = rd_good && (widx == OFS_DOUT);
  assign clr_cmp = wr_good && (widx == OFS_CTRL) && bus_wdata[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0; swap_mode <= SW_NONE; din_dma_en <= 1'b0; dout_dma_en <= 1'b0;
    end else if (wr_good && widx == OFS_CTRL) begin
      en          <= bus_wdata[0];
      swap_mode   <= swap_t'(bus_wdata[2:1]);
      din_dma_en  <= bus_wdata[3];
      dout_dma_en <= bus_wdata[4];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < BLK_WORDS; g++) begin
        key_w[g] <= '0;
        iv_w[g]  <= '0;
      end
    end else if (wr_good) begin
      for (int g = 0; g < BLK_WORDS; g++) begin
        if (widx == IDX_W'(int'(OFS_KEY) + g)) key_w[g] <= bus_wdata;
        if (widx == IDX_W'(int'(OFS_IV) + g))  iv_w[g]  <= bus_wdata;
      end
    end
  end

  always_comb begin
    for (int g = 0; g < BLK_WORDS; g++) begin
      key_flat[BLK_W-1-g*WORD_W -: WORD_W] = key_w[g];
      iv_flat[BLK_W-1-g*WORD_W -: WORD_W]  = iv_w[g];
    end
  end

  always_comb begin
    rd_val = '0;
    case (widx)
      OFS_CTRL: rd_val = {{(WORD_W-5){1'b0}}, dout_dma_en, din_dma_en, swap_mode, en};
      OFS_STAT: rd_val = {{(WORD_W-1){1'b0}}, cmp_flag};
      OFS_DOUT: rd_val = dout_word;
      default:  rd_val = '0;
    endcase
    for (int g = 0; g < BLK_WORDS; g++) begin
      if (widx == IDX_W'(int'(OFS_KEY) + g)) rd_val = key_w[g];
      if (widx == IDX_W'(int'(OFS_IV) + g))  rd_val = iv_w[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_q <= 1'b0; err_ph1 <= 1'b0; err_ph2 <= 1'b0; rdata_q <= '0;
    end else begin
      ok_q    <= good;
      err_ph1 <= bad;
      err_ph2 <= err_ph1;
      rdata_q <= rd_good ? rd_val : '0;
    end
  end

  assign bus_ready = ok_q | err_ph2;
  assign bus_err   = err_ph1 | err_ph2;
  assign bus_rdata = rdata_q;

  AST_ERR_FIRST_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    bad |=> (bus_err && !bus_ready)); // R1
  AST_ERR_SECOND_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    err_ph1 |=> (bus_err && bus_ready)); // R1
  AST_GOOD_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    good |=> (bus_ready && !bus_err)); // R1
  AST_BAD_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (bad && bus_write) |=> ($stable(key_flat) && $stable(iv_flat) &&
                            $stable({en, swap_mode, din_dma_en, dout_dma_en}))); // R2
endmodule

// File: rtl/bbp_engine.sv
module bbp_engine
  import bbp_pkg::*;
#(
  parameter int LAT = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [BLK_W-1:0] blk,
  input  logic [BLK_W-1:0] key,
  input  logic [BLK_W-1:0] iv,
  output logic             done,
  output logic [BLK_W-1:0] result
);
  localparam int CW = $clog2(LAT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; done <= 1'b0; result <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        cnt    <= CW'(LAT);
        result <= blk ^ key ^ iv;
      end else if (cnt != '0) begin
        cnt  <= cnt - 1'b1;
        done <= (cnt == CW'(1));
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
endmodule

// File: rtl/bbp_seq.sv
module bbp_seq
  import bbp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  swap_t             swap_mode,
  input  logic              din_dma_en,
  input  logic              dout_dma_en,
  input  logic              wr_din,
  input  logic [WORD_W-1:0] din_word,
  input  logic              rd_dout,
  input  logic              clr_cmp,
  input  logic              eng_done,
  input  logic [BLK_W-1:0]  eng_result,
  output logic              eng_start,
  output logic [BLK_W-1:0]  blk_flat,
  output logic [WORD_W-1:0] dout_word,
  output logic              dma_in_req,
  output logic              dma_out_req,
  output logic              cmp_flag
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BLK_WORDS - 1);

  phase_t            phase;
  logic [CNT_W-1:0]  in_cnt, out_cnt;
  logic [WORD_W-1:0] blk_w [BLK_WORDS];
  logic [WORD_W-1:0] res_w [BLK_WORDS];
  logic [WORD_W-1:0] din_sw;
  logic              load_we, last_in, finish;

  assign din_sw  = swap_word(swap_mode, din_word);
  assign load_we = en && wr_din && (phase == PH_LOAD);
  assign last_in = load_we && (in_cnt == LAST);
  assign finish  = en && eng_done && (phase == PH_BUSY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_LOAD; in_cnt <= '0; out_cnt <= '0; eng_start <= 1'b0;
      for (int g = 0; g < BLK_WORDS; g++) begin
        blk_w[g] <= '0;
        res_w[g] <= '0;
      end
    end else if (!en) begin
      phase <= PH_LOAD; in_cnt <= '0; out_cnt <= '0; eng_start <= 1'b0;
    end else begin
      eng_start <= 1'b0;
      case (phase)
        PH_LOAD: if (wr_din) begin
          for (int g = 0; g < BLK_WORDS; g++)
            if (in_cnt == CNT_W'(g)) blk_w[g] <= din_sw;
          if (in_cnt == LAST) begin
            in_cnt    <= '0;
            phase     <= PH_BUSY;
            eng_start <= 1'b1;
          end else begin
            in_cnt <= in_cnt + 1'b1;
          end
        end
        PH_BUSY: if (eng_done) begin
          for (int g = 0; g < BLK_WORDS; g++)
            res_w[g] <= eng_result[BLK_W-1-g*WORD_W -: WORD_W];
          phase <= PH_UNLOAD;
        end
        PH_UNLOAD: if (rd_dout) begin
          if (out_cnt == LAST) begin
            out_cnt <= '0;
            phase   <= PH_LOAD;
          end else begin
            out_cnt <= out_cnt + 1'b1;
          end
        end
        default: phase <= PH_LOAD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cmp_flag <= 1'b0;
    else if (finish)  cmp_flag <= 1'b1;
    else if (clr_cmp) cmp_flag <= 1'b0;
  end

  always_comb begin
    for (int g = 0; g < BLK_WORDS; g++)
      blk_flat[BLK_W-1-g*WORD_W -: WORD_W] = blk_w[g];
  end

  assign dout_word   = (phase == PH_UNLOAD) ? swap_word(swap_mode, res_w[out_cnt]) : '0;
  assign dma_in_req  = en && din_dma_en && (phase == PH_LOAD);
  assign dma_out_req = en && dout_dma_en && (phase == PH_UNLOAD);

  AST_START_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    last_in |=> eng_start); // R4
  AST_IN_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    last_in |=> !dma_in_req); // R6
  AST_UNLOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_UNLOAD && en && !rd_dout) |=> (phase == PH_UNLOAD || !en)); // R7
  AST_DONE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> cmp_flag); // R8
  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (in_cnt == '0 && out_cnt == '0)); // R9
  AST_IDLE_READ_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_dout && phase != PH_UNLOAD) |=> $stable(out_cnt)); // R10
endmodule

// File: rtl/blkc_bus_port.sv
module blkc_bus_port
  import bbp_pkg::*;
#(
  parameter int ENG_LAT = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_valid,
  input  logic        bus_write,
  input  logic [1:0]  bus_size,
  input  logic [5:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        bus_ready,
  output logic        bus_err,
  output logic        dma_in_req,
  output logic        dma_out_req
);
  logic              en, din_dma_en, dout_dma_en;
  swap_t             swap_mode;
  logic [BLK_W-1:0]  key_flat, iv_flat, blk_flat, eng_result;
  logic              wr_din, rd_dout, clr_cmp, cmp_flag, eng_start, eng_done;
  logic [WORD_W-1:0] dout_word;

  bbp_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ready(bus_ready), .bus_err(bus_err),
    .en(en), .swap_mode(swap_mode), .din_dma_en(din_dma_en), .dout_dma_en(dout_dma_en),
    .key_flat(key_flat), .iv_flat(iv_flat), .wr_din(wr_din), .rd_dout(rd_dout),
    .clr_cmp(clr_cmp), .dout_word(dout_word), .cmp_flag(cmp_flag)
  );

  bbp_seq u_seq (
    .clk(clk), .rst_n(rst_n), .en(en), .swap_mode(swap_mode),
    .din_dma_en(din_dma_en), .dout_dma_en(dout_dma_en),
    .wr_din(wr_din), .din_word(bus_wdata), .rd_dout(rd_dout), .clr_cmp(clr_cmp),
    .eng_done(eng_done), .eng_result(eng_result), .eng_start(eng_start),
    .blk_flat(blk_flat), .dout_word(dout_word), .dma_in_req(dma_in_req),
    .dma_out_req(dma_out_req), .cmp_flag(cmp_flag)
  );

  bbp_engine #(.LAT(ENG_LAT)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(eng_start), .blk(blk_flat),
    .key(key_flat), .iv(iv_flat), .done(eng_done), .result(eng_result)
  );
endmodule

// File: tb/blkc_bus_port_tb.sv
module blkc_bus_port_tb;
  localparam int LAT = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [1:0]  bus_size = 2'd2;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ready, bus_err, dma_in_req, dma_out_req;
  int n_chk = 0, n_err = 0;

  always #4 clk = ~clk;

  blkc_bus_port #(.ENG_LAT(LAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ready(bus_ready), .bus_err(bus_err),
    .dma_in_req(dma_in_req), .dma_out_req(dma_out_req)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] tb_conv(input int m, input logic [31:0] w);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) begin
      case (m)
        1: r[i] = w[(i + 16) % 32];
        2: r[i] = w[(3 - i / 8) * 8 + i % 8];
        3: r[i] = w[31 - i];
        default: r[i] = w[i];
      endcase
    end
    return r;
  endfunction

  // One access; checks the response phases of R1 and returns read data and error.
  task automatic xfer(input logic wr, input logic [1:0] sz, input logic [5:0] a,
                      input logic [31:0] wd, output logic [31:0] rd, output logic er);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_size = sz; bus_addr = a; bus_wdata = wd;
    @(negedge clk);
    bus_valid = 1'b0;
    rd = bus_rdata; er = bus_err;
    if (er) begin
      check("R1 err phase1 ready", {31'd0, bus_ready}, 32'd0);
      @(negedge clk);
      check("R1 err phase2 ready/err", {30'd0, bus_ready, bus_err}, 32'd3);
    end else begin
      check("R1 good ack", {31'd0, bus_ready}, 32'd1);
    end
  endtask

  task automatic wr_word(input int ofs, input logic [31:0] d);
    logic [31:0] rd; logic er;
    xfer(1'b1, 2'd2, 6'(ofs * 4), d, rd, er);
  endtask

  task automatic rd_word(input int ofs, output logic [31:0] d);
    logic er;
    xfer(1'b0, 2'd2, 6'(ofs * 4), 32'd0, d, er);
  endtask

  logic [31:0] key [4];
  logic [31:0] iv  [4];

  initial begin
    logic [31:0] v, d[4];
    logic er;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R3 reset ready", {31'd0, bus_ready}, 32'd0);
    check("R6 reset in_req", {31'd0, dma_in_req}, 32'd0);
    check("R7 reset out_req", {31'd0, dma_out_req}, 32'd0);
    rd_word(0, v); check("R3 reset ctrl", v, 32'd0);
    rd_word(1, v); check("R3 reset status", v, 32'd0);
    rd_word(5, v); check("R3 reset key word", v, 32'd0);

    // R3: key and IV read back
    for (int i = 0; i < 4; i++) begin
      key[i] = 32'h9E37_79B9 * (i + 1);
      iv[i]  = 32'h7F4A_7C15 ^ (32'h0101_0101 << i);
      wr_word(4 + i, key[i]);
      wr_word(8 + i, iv[i]);
    end
    for (int i = 0; i < 4; i++) begin
      rd_word(4 + i, v); check("R3 key readback", v, key[i]);
      rd_word(8 + i, v); check("R3 iv readback", v, iv[i]);
    end

    // R1/R2: byte, half-word, misaligned accesses
    xfer(1'b1, 2'd0, 6'd16, 32'hDEAD_BEEF, v, er);
    check("R1 byte write error", {31'd0, er}, 32'd1);
    rd_word(4, v); check("R2 key unchanged", v, key[0]);
    xfer(1'b1, 2'd1, 6'd32, 32'h1234_5678, v, er);
    check("R1 half write error", {31'd0, er}, 32'd1);
    rd_word(8, v); check("R2 iv unchanged", v, iv[0]);
    xfer(1'b1, 2'd2, 6'd1, 32'h0000_001F, v, er);
    check("R1 misaligned error", {31'd0, er}, 32'd1);
    rd_word(0, v); check("R2 ctrl unchanged", v, 32'd0);
    xfer(1'b0, 2'd1, 6'd4, 32'd0, v, er);
    check("R1 half read error", {31'd0, er}, 32'd1);

    // R4..R8, R10 across every swap setting
    for (int m = 0; m < 4; m++) begin
      logic [31:0] cfg;
      cfg = 32'h19 | (32'(m) << 1);
      wr_word(0, cfg);
      rd_word(0, v); check("R5 ctrl readback", v, cfg);
      rd_word(3, v); check("R10 idle dout read", v, 32'd0);
      check("R6 in_req loading", {31'd0, dma_in_req}, 32'd1);
      for (int i = 0; i < 4; i++) begin
        d[i] = (32'h0123_4567 + 32'(m) * 32'h1111_1111) ^ (32'h8040_2010 >> i);
        wr_word(2, d[i]);
      end
      check("R6 in_req low after 4th", {31'd0, dma_in_req}, 32'd0);
      for (int k = 1; k <= LAT + 2; k++) begin
        @(negedge clk);
        if (k == LAT + 1) check("R7 out_req not early", {31'd0, dma_out_req}, 32'd0);
        if (k == LAT + 2) check("R7 out_req on time", {31'd0, dma_out_req}, 32'd1);
      end
      rd_word(1, v); check("R8 flag set", v, 32'd1);
      for (int i = 0; i < 4; i++) begin
        rd_word(3, v);
        check("R4 R5 result word", v, tb_conv(m, tb_conv(m, d[i]) ^ key[i] ^ iv[i]));
        if (i < 3) check("R7 out_req held", {31'd0, dma_out_req}, 32'd1);
        check("R6 in_req low unloading", {31'd0, dma_in_req}, i == 3 ? 32'd1 : 32'd0);
      end
      check("R7 out_req drop", {31'd0, dma_out_req}, 32'd0);
      rd_word(1, v); check("R8 flag sticky", v, 32'd1);
      wr_word(0, cfg | 32'h80);
      rd_word(1, v); check("R8 flag cleared", v, 32'd0);
      rd_word(0, v); check("R8 clear bit reads 0", v, cfg);
    end

    // R9: partial block dropped on disable, disabled writes ignored
    wr_word(0, 32'h19);
    wr_word(2, 32'hAAAA_0001);
    wr_word(2, 32'hAAAA_0002);
    wr_word(0, 32'h0);
    check("R9 in_req off disabled", {31'd0, dma_in_req}, 32'd0);
    wr_word(2, 32'hBBBB_0003);
    wr_word(0, 32'h19);
    for (int i = 0; i < 4; i++) begin
      d[i] = 32'hC0DE_0000 + 32'(i * 7);
      wr_word(2, d[i]);
    end
    repeat (LAT + 3) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      rd_word(3, v);
      check("R9 fresh block after disable", v, d[i] ^ key[i] ^ iv[i]);
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule